// File: doc/BRIEF.md
# VIPT Set-Associative Tag Lookup

This block holds the tags and replacement state of a level-one cache that is indexed virtually and tagged physically. The cache holds 32 KiB in 64-byte lines, arranged as 64 sets of 8 ways. The set number comes from virtual address bits 11:6. Those bits lie inside the 12-bit page offset, so they are the same before and after translation. The tag read can therefore start in the same cycle that the translation lookaside buffer starts its own lookup.

One cycle after a lookup is accepted, the translated 20-bit physical page number arrives together with a valid flag. All eight stored page numbers of the set just read are compared with it in parallel. The block then reports hit, the hitting way, and a victim way for a later fill. A fill port writes a page number into a chosen way. An invalidate-all input sweeps every set clear, one set per cycle.

Lookups and fills use valid/ready handshakes. A request transfers on a rising edge where valid and ready are both high. Both ready signals are low while an invalidate sweep runs and high at all other times. The requester must hold its request until ready returns. The result side has no ready signal: each accepted lookup yields exactly one result cycle, and that result cannot be stalled.

Top module: `vipt_tag_lookup`

## Requirements
- R1: The set is selected only by `lk_index`, which carries virtual address bits 11:6. A page number filled into one set never produces a hit for a lookup of another set.
- R2: A lookup accepted on edge N produces `res_valid` high for exactly one cycle, after edge N+1. `pa_valid` and `pa_ppn` are sampled on edge N+1.
- R3: `res_hit` is high when `pa_valid` was high and some valid way of the set holds a page number equal to `pa_ppn`. In that case `res_way` gives the way number in binary.
- R4: When `pa_valid` is low on the compare edge, `res_hit` is low, even if a stored page number matches.
- R5: An accepted fill stores `fill_ppn` in way `fill_way` of set `fill_index` and marks that way valid. A later lookup of that page number hits that way.
- R6: When the set has at least one invalid way, `res_victim` is the lowest-numbered invalid way.
- R7: When all ways of the set are valid, `res_victim` follows a 7-bit tree per set. Node 0 is the root, and the children of node n are nodes 2n+1 and 2n+2. A node bit of 0 means "go to the lower half" and 1 means "go to the upper half". The victim's way bits are the node bits met from the root down, most significant bit first.
- R8: Every hit and every fill sets the three tree nodes on the path of the accessed way to point away from it. A lookup's own `res_victim` reflects the tree as it was before that lookup's hit update.
- R9: A one-cycle `inv_all` pulse drives `lk_ready` and `fill_ready` low for exactly 64 cycles. After that, every way of every set is invalid.
- R10: After reset, no way is valid, `res_valid` is low, and both ready signals are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup can be accepted (low while sweeping) |
| lk_index | input | 6 | Set index, virtual address bits 11:6 |
| pa_valid | input | 1 | Translation succeeded, cycle after acceptance |
| pa_ppn | input | 20 | Translated physical page number |
| fill_valid | input | 1 | Fill request valid |
| fill_ready | output | 1 | Fill can be accepted (low while sweeping) |
| fill_index | input | 6 | Set to fill |
| fill_way | input | 3 | Way to fill |
| fill_ppn | input | 20 | Physical page number to store |
| inv_all | input | 1 | Pulse to start invalidating all sets |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Lookup hit |
| res_way | output | 3 | Hitting way |
| res_victim | output | 3 | Suggested replacement way |

## Verification
The assertions assume that requests are held only through the valid/ready handshake, and that `pa_valid` means something only in the cycle after an accepted lookup. They also assume that `inv_all` is a pulse. The directed stimulus changes inputs only on falling edges. It presents the page number exactly one cycle after acceptance and never overlaps a fill with a lookup of the same set. As a result, every result the bench checks reflects a single, well-defined array state.

// File: rtl/vtl_pkg.sv
package vtl_pkg;
  localparam int VTL_SETS  = 64;
  localparam int VTL_WAYS  = 8;
  localparam int VTL_PPN_W = 20;

  typedef enum logic {SWEEP_IDLE = 1'b0, SWEEP_RUN = 1'b1} sweep_e;
endpackage

// File: rtl/vtl_tag_store.sv
module vtl_tag_store #(
  parameter int SETS  = 64,
  parameter int WAYS  = 8,
  parameter int PPN_W = 20,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_en,
  input  logic [IDX_W-1:0]           rd_idx,
  output logic [WAYS-1:0][PPN_W-1:0] rd_tags,
  output logic [WAYS-1:0]            rd_vlds,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [WAY_W-1:0]           wr_way,
  input  logic [PPN_W-1:0]           wr_ppn,
  input  logic                       clr_en,
  input  logic [IDX_W-1:0]           clr_idx
);
  logic [WAYS-1:0][PPN_W-1:0] tag_mem [SETS];
  logic [WAYS-1:0]            vld_mem [SETS];

  // tag storage needs no reset: valid bits gate every use
  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx][wr_way] <= wr_ppn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_mem[s] <= '0;
    end else begin
      if (clr_en) vld_mem[clr_idx] <= '0;
      if (wr_en)  vld_mem[wr_idx][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_tags <= '0;
      rd_vlds <= '0;
    end else if (rd_en) begin
      rd_tags <= tag_mem[rd_idx];
      rd_vlds <= vld_mem[rd_idx];
    end
  end
endmodule

// File: rtl/vtl_plru.sv
module vtl_plru #(
  parameter int SETS = 64,
  parameter int WAYS = 8,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int NODES = WAYS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [NODES-1:0] rd_tree,
  input  logic             hit_en,
  input  logic [IDX_W-1:0] hit_idx,
  input  logic [WAY_W-1:0] hit_way,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [WAY_W-1:0] fill_way
);
  logic [NODES-1:0] tree_mem [SETS];

  // steer every node on the accessed way's path to the opposite half
  function automatic logic [NODES-1:0] touch(input logic [NODES-1:0] t,
                                             input logic [WAY_W-1:0] w);
    logic [NODES-1:0] n;
    int node;
    n = t;
    node = 0;
    for (int l = 0; l < WAY_W; l++) begin
      n[node] = ~w[WAY_W-1-l];
      node = 2 * node + 1 + int'(w[WAY_W-1-l]);
    end
    return n;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree_mem[s] <= '0;
      rd_tree <= '0;
    end else begin
      if (rd_en)   rd_tree <= tree_mem[rd_idx];
      if (hit_en)  tree_mem[hit_idx] <= touch(tree_mem[hit_idx], hit_way);
      if (fill_en) tree_mem[fill_idx] <= touch(tree_mem[fill_idx], fill_way);
    end
  end
endmodule

// File: rtl/vtl_match.sv
module vtl_match #(
  parameter int WAYS  = 8,
  parameter int PPN_W = 20,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                       en,
  input  logic [WAYS-1:0][PPN_W-1:0] tags,
  input  logic [WAYS-1:0]            vlds,
  input  logic [PPN_W-1:0]           ppn,
  output logic                       hit,
  output logic [WAY_W-1:0]           way
);
  logic [WAYS-1:0] eq;

  for (genvar i = 0; i < WAYS; i++) begin : g_cmp
    assign eq[i] = en && vlds[i] && (tags[i] == ppn);
  end

  always_comb begin
    way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (eq[i]) way = way | WAY_W'(i);
    end
  end

  assign hit = |eq;
endmodule

// File: rtl/vtl_victim.sv
module vtl_victim #(
  parameter int WAYS = 8,
  localparam int WAY_W = $clog2(WAYS),
  localparam int NODES = WAYS - 1
) (
  input  logic [WAYS-1:0]  vlds,
  input  logic [NODES-1:0] tree,
  output logic [WAY_W-1:0] victim
);
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] tree_way;

  always_comb begin
    free_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!vlds[i]) free_way = WAY_W'(i);
    end
  end

  always_comb begin
    int node;
    node = 0;
    tree_way = '0;
    for (int l = 0; l < WAY_W; l++) begin
      tree_way[WAY_W-1-l] = tree[node];
      node = 2 * node + 1 + int'(tree[node]);
    end
  end

  assign victim = (&vlds) ? tree_way : free_way;
endmodule

// File: rtl/vipt_tag_lookup.sv
module vipt_tag_lookup
  import vtl_pkg::*;
#(
  parameter int SETS  = VTL_SETS,
  parameter int WAYS  = VTL_WAYS,
  parameter int PPN_W = VTL_PPN_W,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int NODES = WAYS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [IDX_W-1:0] lk_index,
  input  logic             pa_valid,
  input  logic [PPN_W-1:0] pa_ppn,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic [IDX_W-1:0] fill_index,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             inv_all,
  output logic             res_valid,
  output logic             res_hit,
  output logic [WAY_W-1:0] res_way,
  output logic [WAY_W-1:0] res_victim
);
  sweep_e           sweep_q;
  logic [IDX_W-1:0] sweep_ptr;
  logic             lk_fire, fill_fire;
  logic             s1_valid;
  logic [IDX_W-1:0] s1_idx;

  logic [WAYS-1:0][PPN_W-1:0] set_tags;
  logic [WAYS-1:0]            set_vlds;
  logic [NODES-1:0]           set_tree;
  logic                       m_hit;
  logic [WAY_W-1:0]           m_way;
  logic [WAY_W-1:0]           v_way;

  assign lk_ready   = (sweep_q == SWEEP_IDLE);
  assign fill_ready = (sweep_q == SWEEP_IDLE);
  assign lk_fire    = lk_valid && lk_ready;
  assign fill_fire  = fill_valid && fill_ready;

  // invalidate sweep: one set per cycle, a new pulse restarts it
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sweep_q   <= SWEEP_IDLE;
      sweep_ptr <= '0;
    end else if (inv_all) begin
      sweep_q   <= SWEEP_RUN;
      sweep_ptr <= '0;
    end else if (sweep_q == SWEEP_RUN) begin
      if (sweep_ptr == IDX_W'(SETS - 1)) sweep_q <= SWEEP_IDLE;
      sweep_ptr <= sweep_ptr + 1'b1;
    end
  end

  // stage 1: set read from the untranslated index
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_idx   <= '0;
    end else begin
      s1_valid <= lk_fire;
      if (lk_fire) s1_idx <= lk_index;
    end
  end

  vtl_tag_store #(.SETS(SETS), .WAYS(WAYS), .PPN_W(PPN_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (lk_fire),
    .rd_idx  (lk_index),
    .rd_tags (set_tags),
    .rd_vlds (set_vlds),
    .wr_en   (fill_fire),
    .wr_idx  (fill_index),
    .wr_way  (fill_way),
    .wr_ppn  (fill_ppn),
    .clr_en  (sweep_q == SWEEP_RUN),
    .clr_idx (sweep_ptr)
  );

  vtl_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (lk_fire),
    .rd_idx   (lk_index),
    .rd_tree  (set_tree),
    .hit_en   (m_hit),
    .hit_idx  (s1_idx),
    .hit_way  (m_way),
    .fill_en  (fill_fire),
    .fill_idx (fill_index),
    .fill_way (fill_way)
  );

  // stage 2: compare once the page number is known
  vtl_match #(.WAYS(WAYS), .PPN_W(PPN_W)) u_match (
    .en   (s1_valid && pa_valid),
    .tags (set_tags),
    .vlds (set_vlds),
    .ppn  (pa_ppn),
    .hit  (m_hit),
    .way  (m_way)
  );

  vtl_victim #(.WAYS(WAYS)) u_victim (
    .vlds   (set_vlds),
    .tree   (set_tree),
    .victim (v_way)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_way    <= '0;
      res_victim <= '0;
    end else begin
      res_valid <= s1_valid;
      res_hit   <= m_hit;
      if (s1_valid) begin
        res_way    <= m_way;
        res_victim <= v_way;
      end
    end
  end
endmodule

// File: rtl/vtl_lookup_chk.sv
module vtl_lookup_chk (
  input logic clk,
  input logic rst_n,
  input logic lk_valid,
  input logic lk_ready,
  input logic fill_ready,
  input logic pa_valid,
  input logic inv_all,
  input logic res_valid,
  input logic res_hit
);
  AST_RESULT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> !res_valid) else $error("result too early"); // R2

  AST_HIT_ONLY_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> res_valid) else $error("hit without result"); // R3

  AST_NO_HIT_ON_XLATE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !$past(pa_valid)) |-> !res_hit) else $error("hit after translation miss"); // R4

  AST_SWEEP_BLOCKS_REQS: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (!lk_ready && !fill_ready)) else $error("ready during sweep"); // R9

  AST_LOOKUP_READY_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lk_ready) |-> $fell(fill_ready)) else $error("ready mismatch"); // R9
endmodule

bind vipt_tag_lookup vtl_lookup_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_valid   (lk_valid),
  .lk_ready   (lk_ready),
  .fill_ready (fill_ready),
  .pa_valid   (pa_valid),
  .inv_all    (inv_all),
  .res_valid  (res_valid),
  .res_hit    (res_hit)
);

// File: tb/vipt_tag_lookup_tb.sv
module vipt_tag_lookup_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSETS = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_ready;
  logic [5:0]  lk_index = '0;
  logic        pa_valid = 1'b0;
  logic [19:0] pa_ppn = '0;
  logic        fill_valid = 1'b0, fill_ready;
  logic [5:0]  fill_index = '0;
  logic [2:0]  fill_way = '0;
  logic [19:0] fill_ppn = '0;
  logic        inv_all = 1'b0;
  logic        res_valid, res_hit;
  logic [2:0]  res_way, res_victim;

  int n_checks = 0, n_fails = 0;
  bit done = 1'b0;

  // model built from the requirements
  logic [7:0]  m_vld  [NSETS];
  logic [19:0] m_tag  [NSETS][8];
  logic [6:0]  m_tree [NSETS];

  always #(CLK_PERIOD/2) clk = ~clk;

  vipt_tag_lookup u_dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_index(lk_index), .pa_valid(pa_valid), .pa_ppn(pa_ppn),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_index(fill_index),
    .fill_way(fill_way), .fill_ppn(fill_ppn), .inv_all(inv_all),
    .res_valid(res_valid), .res_hit(res_hit), .res_way(res_way),
    .res_victim(res_victim)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void m_touch(input int s, input int w);
    int node = 0;
    for (int l = 0; l < 3; l++) begin
      int b = (w >> (2 - l)) & 1;
      m_tree[s][node] = ~b[0];
      node = 2 * node + 1 + b;
    end
  endfunction

  function automatic int m_victim(input int s);
    int node = 0, v = 0;
    for (int w = 7; w >= 0; w--) if (!m_vld[s][w]) v = w;
    if (m_vld[s] != 8'hFF) return v;
    for (int l = 0; l < 3; l++) begin
      v = (v << 1) | int'(m_tree[s][node]);
      node = 2 * node + 1 + int'(m_tree[s][node]);
    end
    return v;
  endfunction

  task automatic do_fill(input int s, input int w, input logic [19:0] p);
    @(negedge clk);
    chk(fill_ready, "R5", "fill_ready", fill_ready, 1);
    fill_valid = 1'b1; fill_index = 6'(s); fill_way = 3'(w); fill_ppn = p;
    @(negedge clk);
    fill_valid = 1'b0;
    m_vld[s][w] = 1'b1; m_tag[s][w] = p; m_touch(s, w);
  endtask

  task automatic do_lookup(input int s, input logic [19:0] p, input bit pav,
                           input string req);
    int ehit = 0, eway = 0, evic;
    evic = m_victim(s);
    for (int w = 0; w < 8; w++)
      if (pav && m_vld[s][w] && m_tag[s][w] == p) begin ehit = 1; eway = w; end
    @(negedge clk);
    lk_valid = 1'b1; lk_index = 6'(s);
    @(negedge clk);
    lk_valid = 1'b0; pa_valid = pav; pa_ppn = p;
    chk(!res_valid, "R2", "res_valid early", res_valid, 0);
    @(negedge clk);
    pa_valid = 1'b0;
    chk(res_valid, "R2", "res_valid", res_valid, 1);
    chk(res_hit == ehit[0], req, "res_hit", res_hit, ehit);
    if (ehit != 0) chk(res_way == 3'(eway), req, "res_way", res_way, eway);
    chk(res_victim == 3'(evic), req, "res_victim", res_victim, evic);
    if (ehit != 0) m_touch(s, eway);
    @(negedge clk);
    chk(!res_valid, "R2", "res_valid single", res_valid, 0);
  endtask

  task automatic t_reset_state;
    chk(lk_ready, "R10", "lk_ready", lk_ready, 1);
    chk(fill_ready, "R10", "fill_ready", fill_ready, 1);
    chk(!res_valid, "R10", "res_valid", res_valid, 0);
    do_lookup(9, 20'h00000, 1'b1, "R10");
  endtask

  task automatic t_fill_victims;  // R6 R5
    for (int w = 0; w < 8; w++) begin
      do_lookup(3, 20'hFFFFF, 1'b1, "R6");
      do_fill(3, w, 20'hA0030 + 20'(w));
    end
  endtask

  task automatic t_hits;          // R3 R5 R8
    do_lookup(3, 20'hA0035, 1'b1, "R3");
    do_lookup(3, 20'hA0030, 1'b1, "R5");
    do_lookup(3, 20'hA0037, 1'b1, "R8");
    do_lookup(3, 20'hA0032, 1'b1, "R8");
  endtask

  task automatic t_xlate_miss;    // R4
    do_lookup(3, 20'hA0031, 1'b0, "R4");
    do_lookup(3, 20'hA0031, 1'b1, "R7");
  endtask

  task automatic t_set_isolation; // R1
    do_fill(5, 0, 20'h12345);
    do_lookup(6, 20'h12345, 1'b1, "R1");
    do_lookup(5, 20'h12345, 1'b1, "R1");
  endtask

  task automatic t_plru_order;    // R7 R8
    for (int w = 0; w < 8; w++) do_fill(40, 7 - w, 20'h40000 + 20'(w));
    do_lookup(40, 20'h00001, 1'b1, "R7");
    do_fill(40, 2, 20'h4ABCD);
    do_lookup(40, 20'h00001, 1'b1, "R8");
    do_lookup(40, 20'h4ABCD, 1'b1, "R8");
    do_lookup(40, 20'h00001, 1'b1, "R7");
  endtask

  task automatic t_invalidate;    // R9
    int cnt = 0;
    @(negedge clk); inv_all = 1'b1;
    @(negedge clk); inv_all = 1'b0;
    while (!lk_ready && cnt < 200) begin
      chk(!fill_ready, "R9", "fill_ready in sweep", fill_ready, 0);
      cnt++;
      @(negedge clk);
    end
    chk(cnt == 64, "R9", "sweep cycles", cnt, 64);
    for (int s = 0; s < NSETS; s++) m_vld[s] = '0;
    do_lookup(3, 20'hA0035, 1'b1, "R9");
    do_lookup(5, 20'h12345, 1'b1, "R9");
    do_lookup(63, 20'h00000, 1'b1, "R9");
  endtask

  initial begin
    for (int s = 0; s < NSETS; s++) begin
      m_vld[s] = '0; m_tree[s] = '0;
      for (int w = 0; w < 8; w++) m_tag[s][w] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_fill_victims();
    t_hits();
    t_xlate_miss();
    t_set_isolation();
    t_plru_order();
    t_invalidate();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule